// File: doc/BRIEF.md
# Cascaded Secondary Interrupt Controller

This block collects 32 level-sensitive interrupt requests and presents them to a primary interrupt controller as a 32-line vector. Each input level is registered into a raw-level vector. Bit 0 of that vector is also driven by a software-controlled request flop. The raw vector is gated by an enable register. When any gated request is active, the block raises output line 31, which the primary controller treats as one combined request from this secondary stage.

Inputs 21 to 30 can also skip the combining stage. A separate bypass register, which can only hold bits in that window, routes each selected raw level straight onto the output line with the same index. The primary controller can then service those sources individually.

Software reaches the block through a zero-wait-state APB-style bus with a 4 KB window. The register index is the byte address shifted right by two. The enable and bypass registers have separate set and clear words, so no read-modify-write is needed.

Top module: `sec_irq_ctrl`

## Requirements
- R1: After reset, the enable, bypass, software-request and raw-level registers are zero, all 32 output lines are low, and every defined register reads zero.
- R2: The register index is paddr[11:2], and paddr[1:0] are ignored. Index 0 reads the raw levels AND the enable register, index 1 reads the raw levels, and index 2 reads the enable register.
- R3: A write to index 2 sets every enable bit whose data bit is 1. A write to index 3 clears every enable bit whose data bit is 1. Enable bits whose data bit is 0 keep their value.
- R4: A read of index 4 returns raw-level bit 0 in data bit 0, and bits 31 to 1 read as zero.
- R5: A write of any nonzero value to index 4 sets the software-request flop, and a nonzero write to index 5 clears it. A write of zero to either index leaves the flop unchanged.
- R6: Index 8 reads the bypass register. A write to index 8 sets bypass bits only where the data is 1 within bits 21 to 30 (mask 0x7FE00000). A write to index 9 clears the bypass bits whose data bit is 1.
- R7: For each line i from 21 to 30 with its bypass bit set, output i follows raw-level bit i. Outputs 0 to 20, and any line from 21 to 30 without its bypass bit, stay low.
- R8: Output 31 is high exactly when the raw levels AND the enable register is nonzero. It responds two clock edges after an input change and one edge after the register write that changes the result.
- R9: A read of an undefined index (3, 5, 6, 7, 9 to 1023) returns zero. A write to an undefined index, or to the read-only indices 0 and 1, changes no register and no output.
- R10: Raw-level bit 0 is the registered external input 0 ORed with the software-request flop. Raw bits 31 to 1 are the registered external inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write (1) or read (0) |
| paddr | input | 12 | Byte address within the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| irqIn | input | 32 | Level-sensitive interrupt inputs |
| irqOut | output | 32 | Lines toward the primary controller; bit 31 is the combined request |

## Verification
If an enable or bypass bit is held wrong, it shows on the next read of index 2 or 8. It also shows on the output lines one edge after the write that should have changed it. If the software-request flop or an input register is wrong, the raw-level read shows it at once, and output 31 shows it one edge later. The bench therefore compares the read-back words with the expected register contents after every change. It checks the output vector at the exact edge where the two-stage latency says it must move, so a missing or extra pipeline stage is also exposed.

// File: rtl/sic_pkg.sv
package sic_pkg;
  // Register word indices (byte offset >> 2)
  localparam int WORD_STATUS  = 0;
  localparam int WORD_RAW     = 1;
  localparam int WORD_ENSET   = 2;
  localparam int WORD_ENCLR   = 3;
  localparam int WORD_SOFTSET = 4;
  localparam int WORD_SOFTCLR = 5;
  localparam int WORD_BYPSET  = 8;
  localparam int WORD_BYPCLR  = 9;

  typedef struct packed {
    logic enSet;
    logic enClr;
    logic softSet;
    logic softClr;
    logic bypSet;
    logic bypClr;
  } strobe_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_STATUS,
    RD_RAW,
    RD_ENABLE,
    RD_SOFT,
    RD_BYPASS
  } rdSel_t;
endpackage

// File: rtl/sic_ctrl.sv
module sic_ctrl
  import sic_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output strobe_t           strobes,
  output rdSel_t            rdSel
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             wrAccess;
  logic             rdAccess;
  logic             dataNonZero;
  logic             unusedLowBits;

  assign wordIdx       = paddr[ADDR_W-1:2];
  assign unusedLowBits = ^paddr[1:0];
  assign wrAccess      = psel & penable & pwrite;
  assign rdAccess      = psel & ~pwrite;
  assign dataNonZero   = |pwdata;

  always_comb begin
    strobes = '0;
    if (wrAccess) begin
      case (wordIdx)
        IDX_W'(WORD_ENSET):   strobes.enSet   = 1'b1;
        IDX_W'(WORD_ENCLR):   strobes.enClr   = 1'b1;
        IDX_W'(WORD_SOFTSET): strobes.softSet = dataNonZero;
        IDX_W'(WORD_SOFTCLR): strobes.softClr = dataNonZero;
        IDX_W'(WORD_BYPSET):  strobes.bypSet  = 1'b1;
        IDX_W'(WORD_BYPCLR):  strobes.bypClr  = 1'b1;
        default:              strobes         = '0;
      endcase
    end
  end

  always_comb begin
    rdSel = RD_NONE;
    if (rdAccess) begin
      case (wordIdx)
        IDX_W'(WORD_STATUS):  rdSel = RD_STATUS;
        IDX_W'(WORD_RAW):     rdSel = RD_RAW;
        IDX_W'(WORD_ENSET):   rdSel = RD_ENABLE;
        IDX_W'(WORD_SOFTSET): rdSel = RD_SOFT;
        IDX_W'(WORD_BYPSET):  rdSel = RD_BYPASS;
        default:              rdSel = RD_NONE;
      endcase
    end
  end

  // At most one register is touched by any bus cycle
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes)); // R9

  // No register update outside a write access phase
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(psel && penable && pwrite) |-> (strobes == '0)); // R9

  // Zero data never moves the software request
  AST_SOFT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (pwdata == '0) |-> !(strobes.softSet || strobes.softClr)); // R5
endmodule

// File: rtl/sic_dp.sv
module sic_dp
  import sic_pkg::*;
#(
  parameter int LINES  = 32,
  parameter int BYP_LO = 21,
  parameter int BYP_HI = 30
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] irqIn,
  input  strobe_t          strobes,
  input  logic [LINES-1:0] wdata,
  input  rdSel_t           rdSel,
  output logic [LINES-1:0] rdata,
  output logic [LINES-1:0] irqOut
);
  localparam int COMB_LINE = LINES - 1;

  function automatic logic [LINES-1:0] windowMask();
    logic [LINES-1:0] m;
    m = '0;
    for (int i = BYP_LO; i <= BYP_HI; i++) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [LINES-1:0] BYP_MASK = windowMask();

  logic [LINES-1:0] rawQ;
  logic [LINES-1:0] enReg;
  logic [LINES-1:0] bypReg;
  logic             softQ;
  logic [LINES-1:0] outQ;
  logic [LINES-1:0] levelVec;
  logic [LINES-1:0] masked;
  logic [LINES-1:0] outNext;

  assign levelVec = rawQ | {{(LINES-1){1'b0}}, softQ};
  assign masked   = levelVec & enReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawQ   <= '0;
      enReg  <= '0;
      bypReg <= '0;
      softQ  <= 1'b0;
      outQ   <= '0;
    end else begin
      rawQ <= irqIn;
      outQ <= outNext;
      if (strobes.enSet)   enReg  <= enReg | wdata;
      if (strobes.enClr)   enReg  <= enReg & ~wdata;
      if (strobes.bypSet)  bypReg <= bypReg | (wdata & BYP_MASK);
      if (strobes.bypClr)  bypReg <= bypReg & ~wdata;
      if (strobes.softSet) softQ  <= 1'b1;
      if (strobes.softClr) softQ  <= 1'b0;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : gLine
    if (i == COMB_LINE) begin : gComb
      assign outNext[i] = |masked;
    end else if (i >= BYP_LO && i <= BYP_HI) begin : gByp
      assign outNext[i] = bypReg[i] & levelVec[i];
    end else begin : gIdle
      assign outNext[i] = 1'b0;
    end
  end

  always_comb begin
    case (rdSel)
      RD_STATUS: rdata = masked;
      RD_RAW:    rdata = levelVec;
      RD_ENABLE: rdata = enReg;
      RD_SOFT:   rdata = {{(LINES-1){1'b0}}, levelVec[0]};
      RD_BYPASS: rdata = bypReg;
      default:   rdata = '0;
    endcase
  end

  assign irqOut = outQ;

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rstN)
    strobes.enSet |=> ((enReg & $past(wdata)) == $past(wdata))); // R3

  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rstN)
    strobes.enClr |=> ((enReg & $past(wdata)) == '0)); // R3

  AST_SOFT_SET: assert property (@(posedge clk) disable iff (!rstN)
    strobes.softSet |=> softQ); // R5

  AST_SOFT_CLR: assert property (@(posedge clk) disable iff (!rstN)
    strobes.softClr |=> !softQ); // R5

  AST_BYP_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (bypReg & ~BYP_MASK) == '0); // R6

  AST_QUIET_LINES: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((irqOut[LINES-2:0] & ~$past(bypReg[LINES-2:0])) == '0)); // R7

  AST_COMB_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (|masked) |=> irqOut[COMB_LINE]); // R8

  AST_COMB_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !(|masked) |=> !irqOut[COMB_LINE]); // R8
endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl
  import sic_pkg::*;
#(
  parameter int LINES  = 32,
  parameter int ADDR_W = 12,
  parameter int BYP_LO = 21,
  parameter int BYP_HI = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [LINES-1:0]  pwdata,
  output logic [LINES-1:0]  prdata,
  input  logic [LINES-1:0]  irqIn,
  output logic [LINES-1:0]  irqOut
);
  strobe_t strobes;
  rdSel_t  rdSel;

  sic_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (LINES)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  sic_dp #(
    .LINES  (LINES),
    .BYP_LO (BYP_LO),
    .BYP_HI (BYP_HI)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .irqIn   (irqIn),
    .strobes (strobes),
    .wdata   (pwdata),
    .rdSel   (rdSel),
    .rdata   (prdata),
    .irqOut  (irqOut)
  );
endmodule

// File: tb/sim_sec_irq_ctrl.sv
`timescale 1ns/1ps
module sim_sec_irq_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [31:0] irqIn = '0;
  logic [31:0] irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sec_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irqIn(irqIn), .irqOut(irqOut)
  );

  // {irqIn, enable, expected raw, expected status, expected line 31}
  localparam logic [128:0] VEC [6] = '{
    {32'h0000_0008, 32'h0000_0008, 32'h0000_0008, 32'h0000_0008, 1'b1},
    {32'h0000_00F0, 32'h0000_000F, 32'h0000_00F0, 32'h0000_0000, 1'b0},
    {32'h8000_0001, 32'h8000_0000, 32'h8000_0001, 32'h8000_0000, 1'b1},
    {32'h1234_5678, 32'h0F0F_0F0F, 32'h1234_5678, 32'h0204_0608, 1'b1},
    {32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},
    {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic apbWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; pwdata = '0;
  endtask

  task automatic apbRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", irqOut, 32'h0);
    rstN = 1'b1;
    settle();
    chk("R1 outputs after reset", irqOut, 32'h0);
    apbRead(12'h000, rd); chk("R1 status reset", rd, 32'h0);
    apbRead(12'h004, rd); chk("R1 raw reset", rd, 32'h0);
    apbRead(12'h008, rd); chk("R1 enable reset", rd, 32'h0);
    apbRead(12'h020, rd); chk("R1 bypass reset", rd, 32'h0);

    // Table walk: R2 R3 R8 R10
    for (int v = 0; v < 6; v++) begin
      apbWrite(12'h00C, 32'hFFFF_FFFF);
      apbWrite(12'h008, VEC[v][96:65]);
      @(negedge clk) irqIn = VEC[v][128:97];
      settle();
      apbRead(12'h004, rd); chk("R10 raw levels", rd, VEC[v][64:33]);
      apbRead(12'h000, rd); chk("R2 masked status", rd, VEC[v][32:1]);
      apbRead(12'h008, rd); chk("R3 enable readback", rd, VEC[v][96:65]);
      chk("R8 combined line", {31'b0, irqOut[31]}, {31'b0, VEC[v][0]});
      chk("R7 idle lines", {1'b0, irqOut[30:0]}, 32'h0);
    end

    // R3 partial clear leaves other bits
    apbWrite(12'h008, 32'h0000_00FF);
    apbWrite(12'h00C, 32'h0000_000F);
    apbRead(12'h008, rd); chk("R3 partial clear", rd, 32'hFFFF_FFF0);
    apbWrite(12'h00C, 32'hFFFF_FFFF);

    // R8 latency from input
    @(negedge clk) irqIn = 32'h0;
    apbWrite(12'h008, 32'h0000_0008);
    settle();
    chk("R8 idle before input", {31'b0, irqOut[31]}, 32'h0);
    irqIn = 32'h0000_0008;
    @(negedge clk);
    chk("R8 one edge after input", {31'b0, irqOut[31]}, 32'h0);
    @(negedge clk);
    chk("R8 two edges after input", {31'b0, irqOut[31]}, 32'h1);

    // R8 latency from enable write
    irqIn = 32'h0000_0020;
    apbWrite(12'h00C, 32'hFFFF_FFFF);
    settle();
    chk("R8 off before enable", {31'b0, irqOut[31]}, 32'h0);
    apbWrite(12'h008, 32'h0000_0020);
    chk("R8 same edge as write", {31'b0, irqOut[31]}, 32'h0);
    @(negedge clk);
    chk("R8 one edge after write", {31'b0, irqOut[31]}, 32'h1);
    apbWrite(12'h00C, 32'hFFFF_FFFF);

    // R4 and R10 on bit 0
    irqIn = 32'h0000_0001;
    settle();
    apbRead(12'h010, rd); chk("R10 external bit0 read", rd, 32'h1);
    irqIn = 32'hFFFF_FFFE;
    settle();
    apbRead(12'h010, rd); chk("R4 upper bits hidden", rd, 32'h0);
    apbRead(12'h004, rd); chk("R10 raw without bit0", rd, 32'hFFFF_FFFE);
    irqIn = 32'h0;

    // R5 software request
    apbWrite(12'h010, 32'h0);
    apbRead(12'h004, rd); chk("R5 zero set ignored", rd, 32'h0);
    apbWrite(12'h010, 32'h0000_0100);
    apbRead(12'h010, rd); chk("R5 soft set", rd, 32'h1);
    apbRead(12'h004, rd); chk("R10 soft in raw", rd, 32'h1);
    apbWrite(12'h008, 32'h0000_0001);
    settle();
    chk("R5 soft drives line 31", irqOut, 32'h8000_0000);
    apbWrite(12'h014, 32'h0);
    apbRead(12'h010, rd); chk("R5 zero clear ignored", rd, 32'h1);
    apbWrite(12'h014, 32'h8000_0000);
    apbRead(12'h010, rd); chk("R5 soft cleared", rd, 32'h0);
    settle();
    chk("R5 line 31 drops", irqOut, 32'h0);
    apbWrite(12'h00C, 32'hFFFF_FFFF);

    // R6 / R7 bypass
    irqIn = 32'hFFFF_FFFF;
    apbWrite(12'h020, 32'hFFFF_FFFF);
    apbRead(12'h020, rd); chk("R6 set limited to window", rd, 32'h7FE0_0000);
    settle();
    chk("R7 bypassed lines follow", irqOut, 32'h7FE0_0000);
    apbWrite(12'h024, 32'h0200_0000);
    apbRead(12'h020, rd); chk("R6 clear one bit", rd, 32'h7DE0_0000);
    settle();
    chk("R7 cleared line quiet", irqOut, 32'h7DE0_0000);
    irqIn = 32'h0040_0000;
    settle();
    chk("R7 follows single input", irqOut, 32'h0040_0000);
    irqIn = 32'h0;
    settle();
    chk("R7 follows input low", irqOut, 32'h0);
    apbWrite(12'h024, 32'hFFFF_FFFF);
    apbRead(12'h020, rd); chk("R6 clear all", rd, 32'h0);

    // R9 undefined and read-only words; R2 low address bits
    apbWrite(12'h008, 32'h0000_00FF);
    irqIn = 32'h0000_0011;
    settle();
    apbWrite(12'h018, 32'hFFFF_FFFF);
    apbWrite(12'h01C, 32'hFFFF_FFFF);
    apbWrite(12'h028, 32'hFFFF_FFFF);
    apbWrite(12'hFFC, 32'hFFFF_FFFF);
    apbWrite(12'h000, 32'hFFFF_FFFF);
    apbWrite(12'h004, 32'hFFFF_FFFF);
    settle();
    apbRead(12'h018, rd); chk("R9 undefined read 6", rd, 32'h0);
    apbRead(12'h024, rd); chk("R9 undefined read 9", rd, 32'h0);
    apbRead(12'hFFC, rd); chk("R9 undefined read top", rd, 32'h0);
    apbRead(12'h00C, rd); chk("R9 undefined read 3", rd, 32'h0);
    apbRead(12'h000, rd); chk("R9 status unchanged", rd, 32'h0000_0011);
    apbRead(12'h004, rd); chk("R9 raw unchanged", rd, 32'h0000_0011);
    apbRead(12'h00B, rd); chk("R2 low bits ignored", rd, 32'h0000_00FF);
    apbRead(12'h020, rd); chk("R9 bypass unchanged", rd, 32'h0);
    apbRead(12'h010, rd); chk("R9 soft from input only", rd, 32'h1);
    chk("R9 outputs unchanged", irqOut, 32'h8000_0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule